// File: doc/BRIEF.md
# Floating-Point Control Register with Rounding and Accuracy Resolution

This block keeps the floating-point control state for one hart. It holds three fields: the sticky exception flags, a dynamic rounding mode and a dynamic accuracy mode. For every floating-point operation it also works out which modes apply. The static rounding field of the instruction either names a rounding mode directly or defers to the stored one. The stored accuracy mode goes to the execution unit unchanged. The accuracy mode only changes how precise a result must be. Operand and result formats never change.

An operation is stopped with an illegal-instruction trap in two cases. The first is a deferred rounding mode whose stored value is not a legal mode. The second is an accuracy mode that the hardware cannot deliver for that class of operation, so that software can emulate it. A parameter bitmask, indexed by operation class and accuracy code, lists the pairs that the hardware supports. Software reaches the state through one CSR port that has three access views.

Top module: `fpctl_top`

## Requirements
- R1: After reset, all three fields are zero. A full-view read returns 0, so the accuracy mode starts at correctly rounded (code 000).
- R2: Reads are combinational and valid while `csr_en` is high. In the full view (`csr_view`=0), bits [4:0] are the flags, [7:5] the rounding mode and [10:8] the accuracy mode. Bits [31:11] read as zero and writes to them are dropped.
- R3: The rounding view (`csr_view`=1) reads and writes only the rounding mode, in bits [2:0]. The flags view (`csr_view`=2) reads and writes only the flags, in bits [4:0]. All other read bits are zero.
- R4: View code 3 reads as zero, and writes through it change no field.
- R5: When `op_rm` is not 111, `eff_rm` equals `op_rm` and the rounding field does not trap.
- R6: When `op_rm` is 111, `eff_rm` is the stored rounding mode. If that mode is 101, 110 or 111 and `op_valid` is high, `op_trap` is high.
- R7: `eff_acc` is the stored accuracy mode. The codes are 000 correctly rounded, 010 under one ULP, 100 GPU-grade and 110 approximate. A valid operation traps unless bit `op_cls*8+acc` of `SUPPORT_MASK` is set. Odd codes always trap.
- R8: A valid operation that does not trap ORs `op_flags` into the flags. The result can be read in the next cycle.
- R9: When a CSR write to the flags field falls in the same cycle as a flag merge, the written value wins.
- R10: A trapping operation leaves the flags unchanged.
- R11: `op_trap`, `eff_rm` and `eff_acc` are combinational. They use the register contents from before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_en | input | 1 | CSR access strobe |
| csr_view | input | 2 | Access view: 0 full, 1 rounding, 2 flags, 3 none |
| csr_we | input | 1 | Write enable for the access |
| csr_wdata | input | XLEN | Write data, right-aligned for each view |
| csr_rdata | output | XLEN | Read data for the selected view |
| op_valid | input | 1 | Floating-point operation strobe |
| op_rm | input | 3 | Static rounding field of the instruction |
| op_cls | input | CLS_W | Operation class |
| op_flags | input | 5 | Exception flags raised by the operation |
| eff_rm | output | 3 | Resolved rounding mode |
| eff_acc | output | 3 | Resolved accuracy mode |
| op_trap | output | 1 | Illegal-instruction trap |

## Verification
The bench builds the block with four operation classes and `SUPPORT_MASK` = 32'h05015515:
- class 0 supports codes 000, 010 and 100;
- class 1 supports all four even codes;
- class 2 supports only 000;
- class 3 supports 000 and 010.

With this mask, one accuracy code is accepted for one class and trapped for another, so the pair-level rule is covered. Class 1 accepts every even code, which leaves the odd-code trap as the only possible cause of a trap there. Class 2 shows the minimal implementation, where every code other than correctly rounded traps.

// File: rtl/fpctl_pkg.sv
package fpctl_pkg;
   localparam int FLAG_W  = 5;
   localparam int RM_W    = 3;
   localparam int ACC_W   = 3;
   localparam int FLAG_LO = 0;
   localparam int RM_LO   = FLAG_LO + FLAG_W;
   localparam int ACC_LO  = RM_LO + RM_W;
   localparam int USED_W  = ACC_LO + ACC_W;
   localparam int ACC_CODES = 1 << ACC_W;

   localparam logic [RM_W-1:0] RM_DEFER     = 3'b111;
   localparam logic [RM_W-1:0] RM_FIRST_BAD = 3'b101;

   typedef enum logic [1:0] {
      VIEW_FULL  = 2'd0,
      VIEW_RM    = 2'd1,
      VIEW_FLAGS = 2'd2,
      VIEW_NONE  = 2'd3
   } csr_view_e;
endpackage

// File: rtl/fpctl_regs.sv
module fpctl_regs
   import fpctl_pkg::*;
#(
   parameter int XLEN = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_en,
   input  logic              csr_we,
   input  csr_view_e         view,
   input  logic [XLEN-1:0]   wdata,
   input  logic              merge_en,
   input  logic [FLAG_W-1:0] merge_flags,
   output logic [XLEN-1:0]   rdata,
   output logic [FLAG_W-1:0] flags_q,
   output logic [RM_W-1:0]   frm_q,
   output logic [ACC_W-1:0]  acc_q
);
   generate
      if (XLEN < USED_W) begin : g_bad_xlen
         $error("fpctl_regs: XLEN too small for the field layout");
      end
   endgenerate

   logic wr;
   logic wr_flags;
   logic wr_rm;
   logic wr_acc;

   assign wr       = csr_en && csr_we;
   assign wr_flags = wr && (view == VIEW_FULL || view == VIEW_FLAGS);
   assign wr_rm    = wr && (view == VIEW_FULL || view == VIEW_RM);
   assign wr_acc   = wr && (view == VIEW_FULL);

   logic unused_wdata;
   assign unused_wdata = ^wdata[XLEN-1:USED_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         frm_q   <= '0;
         acc_q   <= '0;
      end else begin
         if (wr_flags) begin
            flags_q <= (view == VIEW_FULL) ? wdata[FLAG_LO +: FLAG_W] : wdata[FLAG_W-1:0];
         end else if (merge_en) begin
            flags_q <= flags_q | merge_flags;
         end
         if (wr_rm) begin
            frm_q <= (view == VIEW_FULL) ? wdata[RM_LO +: RM_W] : wdata[RM_W-1:0];
         end
         if (wr_acc) begin
            acc_q <= wdata[ACC_LO +: ACC_W];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (csr_en) begin
         unique case (view)
            VIEW_FULL: begin
               rdata[FLAG_LO +: FLAG_W] = flags_q;
               rdata[RM_LO +: RM_W]     = frm_q;
               rdata[ACC_LO +: ACC_W]   = acc_q;
            end
            VIEW_RM:    rdata[RM_W-1:0]   = frm_q;
            VIEW_FLAGS: rdata[FLAG_W-1:0] = flags_q;
            default:    rdata = '0;
         endcase
      end
   end

   a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      csr_en && view == VIEW_FULL |-> rdata[XLEN-1:USED_W] == '0);

   a_r4_none_view: assert property (@(posedge clk) disable iff (!rst_n)
      csr_en && view == VIEW_NONE && csr_we |=>
         flags_q == $past(flags_q) || $past(merge_en));

   a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> flags_q == '0 && frm_q == '0 && acc_q == '0);
endmodule

// File: rtl/fpctl_rm_resolve.sv
module fpctl_rm_resolve
   import fpctl_pkg::*;
(
   input  logic [RM_W-1:0] op_rm,
   input  logic [RM_W-1:0] frm_q,
   output logic [RM_W-1:0] eff_rm,
   output logic            rm_bad
);
   logic defer;
   assign defer  = (op_rm == RM_DEFER);
   assign eff_rm = defer ? frm_q : op_rm;
   assign rm_bad = defer && (frm_q >= RM_FIRST_BAD);
endmodule

// File: rtl/fpctl_acc_check.sv
module fpctl_acc_check
   import fpctl_pkg::*;
#(
   parameter int NUM_OPCLS = 4,
   parameter logic [NUM_OPCLS*ACC_CODES-1:0] SUPPORT_MASK = '1,
   localparam int CLS_W = (NUM_OPCLS > 1) ? $clog2(NUM_OPCLS) : 1,
   localparam int TBL_N = 1 << CLS_W
)(
   input  logic [CLS_W-1:0] op_cls,
   input  logic [ACC_W-1:0] acc,
   output logic             acc_ok
);
   localparam logic [ACC_CODES-1:0] EVEN_ONLY = 8'h55;

   generate
      if (NUM_OPCLS < 1) begin : g_bad_cls
         $error("fpctl_acc_check: NUM_OPCLS must be at least 1");
      end
   endgenerate

   logic [ACC_CODES-1:0] tbl [TBL_N];

   for (genvar c = 0; c < TBL_N; c++) begin : g_cls
      if (c < NUM_OPCLS) begin : g_real
         if (!SUPPORT_MASK[c*ACC_CODES]) begin : g_no_ieee
            $error("fpctl_acc_check: every class must support code 000");
         end
         assign tbl[c] = SUPPORT_MASK[c*ACC_CODES +: ACC_CODES] & EVEN_ONLY;
      end else begin : g_pad
         assign tbl[c] = '0;
      end
   end

   assign acc_ok = tbl[op_cls][acc];
endmodule

// File: rtl/fpctl_top.sv
module fpctl_top
   import fpctl_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int NUM_OPCLS = 4,
   parameter logic [NUM_OPCLS*ACC_CODES-1:0] SUPPORT_MASK = 32'h05015515,
   localparam int CLS_W = (NUM_OPCLS > 1) ? $clog2(NUM_OPCLS) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_en,
   input  logic [1:0]        csr_view,
   input  logic              csr_we,
   input  logic [XLEN-1:0]   csr_wdata,
   output logic [XLEN-1:0]   csr_rdata,
   input  logic              op_valid,
   input  logic [2:0]        op_rm,
   input  logic [CLS_W-1:0]  op_cls,
   input  logic [4:0]        op_flags,
   output logic [2:0]        eff_rm,
   output logic [2:0]        eff_acc,
   output logic              op_trap
);
   csr_view_e         view;
   logic [FLAG_W-1:0] flags_q;
   logic [RM_W-1:0]   frm_q;
   logic [ACC_W-1:0]  acc_q;
   logic              rm_bad;
   logic              acc_ok;
   logic              merge_en;

   assign view = csr_view_e'(csr_view);

   fpctl_regs #(.XLEN(XLEN)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .csr_en      (csr_en),
      .csr_we      (csr_we),
      .view        (view),
      .wdata       (csr_wdata),
      .merge_en    (merge_en),
      .merge_flags (op_flags),
      .rdata       (csr_rdata),
      .flags_q     (flags_q),
      .frm_q       (frm_q),
      .acc_q       (acc_q)
   );

   fpctl_rm_resolve u_rm (
      .op_rm  (op_rm),
      .frm_q  (frm_q),
      .eff_rm (eff_rm),
      .rm_bad (rm_bad)
   );

   fpctl_acc_check #(
      .NUM_OPCLS    (NUM_OPCLS),
      .SUPPORT_MASK (SUPPORT_MASK)
   ) u_acc (
      .op_cls (op_cls),
      .acc    (acc_q),
      .acc_ok (acc_ok)
   );

   assign eff_acc  = acc_q;
   assign op_trap  = op_valid && (rm_bad || !acc_ok);
   assign merge_en = op_valid && !op_trap;

   logic flag_wr;
   assign flag_wr = csr_en && csr_we && (view == VIEW_FULL || view == VIEW_FLAGS);

   a_r6_dyn_trap: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_rm == RM_DEFER && csr_rdata == '0 && frm_q >= RM_FIRST_BAD |-> op_trap);

   a_r7_odd_trap: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && eff_acc[0] |-> op_trap);

   a_r8_flag_merge: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !op_trap && !flag_wr |=> (flags_q & $past(op_flags)) == $past(op_flags));

   a_r10_trap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_trap && !flag_wr |=> flags_q == $past(flags_q));
endmodule

// File: tb/fpctl_top_tb.sv
module fpctl_top_tb;
   localparam int XLEN = 32;
   localparam int NCLS = 4;
   localparam logic [31:0] MASK = 32'h05015515;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_en = 1'b0;
   logic [1:0]  csr_view = 2'd0;
   logic        csr_we = 1'b0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        op_valid = 1'b0;
   logic [2:0]  op_rm = '0;
   logic [1:0]  op_cls = '0;
   logic [4:0]  op_flags = '0;
   logic [2:0]  eff_rm;
   logic [2:0]  eff_acc;
   logic        op_trap;

   always #5 clk = ~clk;

   fpctl_top #(.XLEN(XLEN), .NUM_OPCLS(NCLS), .SUPPORT_MASK(MASK)) u_dut (
      .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_view(csr_view),
      .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .op_valid(op_valid), .op_rm(op_rm), .op_cls(op_cls), .op_flags(op_flags),
      .eff_rm(eff_rm), .eff_acc(eff_acc), .op_trap(op_trap)
   );

   typedef struct {
      string       req;
      int          sel;
      logic [31:0] exp;
   } item_t;

   item_t q[$];
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [4:0] m_flags = '0;
   logic [2:0] m_frm   = '0;
   logic [2:0] m_acc   = '0;

   function automatic logic [31:0] m_read(input logic [1:0] v);
      case (v)
         2'd0:    return {21'd0, m_acc, m_frm, m_flags};
         2'd1:    return {29'd0, m_frm};
         2'd2:    return {27'd0, m_flags};
         default: return 32'd0;
      endcase
   endfunction

   function automatic bit m_trap(input logic [2:0] rm, input logic [1:0] cls);
      bit bad_rm;
      bit ok_acc;
      bad_rm = (rm == 3'b111) && (m_frm >= 3'd5);
      ok_acc = !m_acc[0] && MASK[cls*8 + m_acc];
      return bad_rm || !ok_acc;
   endfunction

   task automatic push(input string req, input int sel, input logic [31:0] exp);
      item_t it;
      it.req = req; it.sel = sel; it.exp = exp;
      q.push_back(it);
   endtask

   task automatic step(input bit en, input logic [1:0] v, input bit we,
                       input logic [31:0] wd, input bit opv, input logic [2:0] rm,
                       input logic [1:0] cls, input logic [4:0] fl, input string req);
      bit t;
      @(negedge clk);
      csr_en = en; csr_view = v; csr_we = we; csr_wdata = wd;
      op_valid = opv; op_rm = rm; op_cls = cls; op_flags = fl;
      t = 1'b0;
      if (en && !we) push(req, 0, m_read(v));
      if (opv) begin
         t = m_trap(rm, cls);
         push(req, 1, {31'd0, t});
         push(req, 2, {29'd0, (rm == 3'b111) ? m_frm : rm});
         push(req, 3, {29'd0, m_acc});
      end
      if (en && we && (v == 2'd0 || v == 2'd2))
         m_flags = (v == 2'd0) ? wd[4:0] : wd[4:0];
      else if (opv && !t)
         m_flags = m_flags | fl;
      if (en && we && v == 2'd0) begin m_frm = wd[7:5]; m_acc = wd[10:8]; end
      if (en && we && v == 2'd1) m_frm = wd[2:0];
   endtask

   task automatic rd(input logic [1:0] v, input string req);
      step(1, v, 0, '0, 0, 3'd0, 2'd0, 5'd0, req);
   endtask
   task automatic wr(input logic [1:0] v, input logic [31:0] d, input string req);
      step(1, v, 1, d, 0, 3'd0, 2'd0, 5'd0, req);
   endtask
   task automatic op(input logic [2:0] rm, input logic [1:0] cls, input logic [4:0] fl,
                     input string req);
      step(0, 2'd0, 0, '0, 1, rm, cls, fl, req);
   endtask

   initial begin : monitor
      forever begin
         @(negedge clk);
         #3;
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.sel)
               0:       act = csr_rdata;
               1:       act = {31'd0, op_trap};
               2:       act = {29'd0, eff_rm};
               default: act = {29'd0, eff_acc};
            endcase
            checks++;
            if (act !== it.exp) begin
               fails++;
               $display("FAIL %s: sel %0d got %h expected %h", it.req, it.sel, act, it.exp);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1");
      op(3'd0, 2'd2, 5'd0, "R1");
      wr(2'd0, 32'hFFFF_FFFF, "R2");
      rd(2'd0, "R2");
      wr(2'd0, 32'h0, "R2");
      wr(2'd1, 32'hFFFF_FFFA, "R3");
      rd(2'd1, "R3"); rd(2'd0, "R3");
      wr(2'd2, 32'hFFFF_FFF3, "R3");
      rd(2'd2, "R3"); rd(2'd0, "R3");
      wr(2'd3, 32'hFFFF_FFFF, "R4");
      rd(2'd3, "R4"); rd(2'd0, "R4");
      wr(2'd2, 32'h0, "R5");
      op(3'b001, 2'd0, 5'd0, "R5");
      op(3'b101, 2'd0, 5'd0, "R5");
      op(3'b111, 2'd0, 5'd0, "R6");
      for (int r = 5; r < 8; r++) begin
         wr(2'd1, r, "R6");
         op(3'b111, 2'd0, 5'd0, "R6");
         op(3'b011, 2'd3, 5'd0, "R6");
      end
      wr(2'd1, 32'h0, "R7");
      wr(2'd0, 32'h200, "R7");
      op(3'd0, 2'd0, 5'd0, "R7"); op(3'd0, 2'd2, 5'd0, "R7"); op(3'd0, 2'd3, 5'd0, "R7");
      wr(2'd0, 32'h600, "R7");
      op(3'd0, 2'd1, 5'd0, "R7"); op(3'd0, 2'd0, 5'd0, "R7");
      for (int a = 1; a < 8; a += 2) begin
         wr(2'd0, a << 8, "R7");
         op(3'd0, 2'd1, 5'd0, "R7");
      end
      wr(2'd0, 32'h0, "R8");
      op(3'd0, 2'd0, 5'b00001, "R8");
      rd(2'd2, "R8");
      op(3'd2, 2'd1, 5'b10100, "R8");
      rd(2'd2, "R8");
      step(1, 2'd2, 1, 32'h2, 1, 3'd0, 2'd0, 5'b01000, "R9");
      rd(2'd2, "R9");
      step(1, 2'd1, 1, 32'h1, 1, 3'd0, 2'd0, 5'b00100, "R9");
      rd(2'd0, "R9");
      wr(2'd0, 32'h102, "R10");
      op(3'd0, 2'd0, 5'b11111, "R10");
      rd(2'd2, "R10");
      step(1, 2'd0, 1, 32'h0, 1, 3'd0, 2'd2, 5'd0, "R11");
      op(3'd0, 2'd2, 5'd0, "R11");
      step(0, 2'd0, 0, '0, 0, 3'd0, 2'd0, 5'd0, "idle");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule